// File: doc/BRIEF.md
# Multiply-Accumulate Side Unit

This block is a 32 x 32 unsigned multiplier with a 64-bit accumulator. It sits beside a small processor and is reached through a register-transfer side port. The processor moves whole bytes between its own register file and a window of three peripheral registers. It writes the block with a transfer-out and reads it back with a transfer-in. Both operands are wired straight from two fixed processor registers. A per-cycle tick marks each processor step.

The unit works in one of two modes. In multiply-only mode, each tick captures both operands and stores their full 64-bit product, and the accumulator is held at zero. In accumulate mode, ticks have no effect. The operands are captured only when a transfer-out starts at the control register. That capture adds their product to the accumulator, and the new sum is also placed in the product registers. When the 64-bit sum wraps, a carry flag is raised. The processor clears that flag by writing a 1 to it, and the same write also empties the accumulator.

Top module: `mac_side_unit`

## Requirements
- R1: After reset, the mode bit, the carry flag, both product words and the accumulator are zero, so a readback of the whole window returns all zeros.
- R2: The window covers processor registers 25, 26 and 27, four bytes each, giving window bytes 0..11. Register 25 is the control register: bit 0 is the mode (1 = accumulate), bit 1 is the carry flag, and every other bit reads 0. Register 26 holds product bits 31:0 and register 27 holds product bits 63:32. A transfer that starts at register r, lane b and runs for n bytes covers window bytes (r-25)*4+b up to (r-25)*4+b+n-1, stepping into the next register after lane 3. Transfer byte k sits in data bits 8k+7:8k. Readback data is combinational from the current state, and bytes beyond n read 0.
- R3: A transfer is rejected in the same cycle (its err output is high) if any of these holds: it starts outside 25..27, its length is 0, or it runs past byte 11. A rejected transfer-out changes no state, and a rejected transfer-in returns all-zero data.
- R4: In multiply-only mode, a tick stores opa*opb (64-bit unsigned) in the product words and zeroes the accumulator. The result is visible from the next cycle.
- R5: In multiply-only mode, cycles without a tick leave the product unchanged, even when the operands move.
- R6: In accumulate mode, ticks and operand changes leave the product and the accumulator unchanged.
- R7: A transfer-out that starts at register 25 and leaves the mode bit at 1 sets the accumulator to (accumulator + opa*opb) mod 2^64 and writes the same value to the product words. This happens whatever the lane and length of the transfer.
- R8: When that sum is lower than the previous accumulator, the carry flag is set. Apart from R9, the carry flag stays set, and it is driven on carry_o.
- R9: Writing a 1 to control bit 1 clears the carry flag and zeroes the accumulator. The clear happens before any accumulation in the same transfer. Writing a 0 to bit 1 leaves the flag as it is.
- R10: A transfer-out that covers bytes of registers 26 or 27 overwrites exactly those product bytes. It does not touch the accumulator.
- R11: When a tick and a transfer-out arrive in the same cycle, the transfer takes effect first. If the resulting mode is multiply-only, the tick's product then replaces the product words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One pulse per processor step |
| opa_i | input | 32 | First operand (processor register 28) |
| opb_i | input | 32 | Second operand (processor register 29) |
| wr_en_i | input | 1 | Transfer-out strobe |
| wr_sel_i | input | 5 | Transfer-out starting register number |
| wr_lane_i | input | 2 | Transfer-out starting byte lane |
| wr_len_i | input | 4 | Transfer-out length in bytes |
| wr_data_i | input | 96 | Transfer-out bytes, byte k in bits 8k+7:8k |
| wr_err_o | output | 1 | Transfer-out rejected |
| rd_en_i | input | 1 | Transfer-in request |
| rd_sel_i | input | 5 | Transfer-in starting register number |
| rd_lane_i | input | 2 | Transfer-in starting byte lane |
| rd_len_i | input | 4 | Transfer-in length in bytes |
| rd_data_o | output | 96 | Transfer-in bytes, byte k in bits 8k+7:8k |
| rd_err_o | output | 1 | Transfer-in rejected |
| carry_o | output | 1 | Accumulator carry flag |

## Verification
Operand pairs at all-ones are run next to random pairs. All-ones products make the second accumulation wrap, so the carry path and its write-1 clear can be told apart from a plain sum. Random start register, lane and length, with invalid values mixed in, separate correct lane stepping from an off-by-one at a register boundary, and also exercise the rejection rules. Ticks are given alone, together with transfer-outs, and in both modes. These cases separate per-tick multiply-only capture from capture on a control-register write, and they check the priority between a transfer and a tick in the same cycle.

// File: rtl/mac_side_pkg.sv
package mac_side_pkg;
  parameter int unsigned MAC_OP_W  = 32;
  localparam int unsigned MAC_ACC_W = 2 * MAC_OP_W;

  typedef logic [MAC_OP_W-1:0]  mac_op_t;
  typedef logic [MAC_ACC_W-1:0] mac_acc_t;

  typedef struct packed {
    mac_acc_t sum;
    logic     wrap;
  } mac_sum_t;

  // Full-width unsigned product.
  function automatic mac_acc_t mac_mul(input mac_op_t a, input mac_op_t b);
    return {{MAC_OP_W{1'b0}}, a} * {{MAC_OP_W{1'b0}}, b};
  endfunction

  // Modular add; wrap is flagged when the result falls below the old value.
  function automatic mac_sum_t mac_add(input mac_acc_t old_acc, input mac_acc_t addend);
    mac_sum_t r;
    r.sum  = old_acc + addend;
    r.wrap = (r.sum < old_acc);
    return r;
  endfunction
endpackage

// File: rtl/mac_xfer_dec.sv
module mac_xfer_dec #(
  parameter int BASE_REG = 25,
  parameter int NREG     = 3,
  parameter int RB       = 4,
  parameter int SEL_W    = 5,
  parameter int LANE_W   = 2,
  parameter int LEN_W    = 4,
  localparam int WIN_B   = NREG * RB
) (
  input  logic              en_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              ok_o,
  output logic              err_o,
  output logic [7:0]        start_o,
  output logic [WIN_B-1:0]  mask_o
);
  logic [7:0] rel_w, stop_w;
  logic       in_rng_w;

  always_comb begin
    rel_w    = 8'(sel_i) - 8'(BASE_REG);
    in_rng_w = (rel_w < 8'(NREG));
    start_o  = rel_w * 8'(RB) + 8'(lane_i);
    stop_w   = start_o + 8'(len_i);
    ok_o     = en_i && in_rng_w && (len_i != '0) && (stop_w <= 8'(WIN_B));
    err_o    = en_i && !ok_o;
  end

  for (genvar j = 0; j < WIN_B; j++) begin : g_mask
    assign mask_o[j] = ok_o && (8'(j) >= start_o) && (8'(j) < stop_w);
  end
endmodule

// File: rtl/mac_core.sv
module mac_core
  import mac_side_pkg::*;
#(
  parameter int RB    = MAC_OP_W / 8,
  localparam int WIN_B = 3 * RB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  mac_op_t          opa_i,
  input  mac_op_t          opb_i,
  input  logic             wr_ok_i,
  input  logic             touch_i,
  input  logic [WIN_B-1:0] wr_mask_i,
  input  logic [8*WIN_B-1:0] wr_win_i,
  output logic             mode_o,
  output logic             carry_o,
  output mac_acc_t         prod_o,
  output mac_acc_t         acc_o
);
  logic     mode_q, mode_n, carry_q, carry_n;
  mac_acc_t prod_q, prod_n, acc_q, acc_n;
  mac_sum_t step_w;
  logic     unused_mode_bits;

  assign unused_mode_bits = ^wr_win_i[8*RB-1:2];

  always_comb begin
    mode_n  = mode_q;
    carry_n = carry_q;
    prod_n  = prod_q;
    acc_n   = acc_q;
    step_w  = '0;
    if (wr_ok_i) begin
      if (wr_mask_i[0]) begin
        mode_n = wr_win_i[0];
        if (wr_win_i[1]) begin
          carry_n = 1'b0;
          acc_n   = '0;
        end
      end
      for (int j = 0; j < 2 * RB; j++) begin
        if (wr_mask_i[RB + j]) prod_n[8*j +: 8] = wr_win_i[8*(RB + j) +: 8];
      end
      if (touch_i && mode_n) begin
        step_w = mac_add(acc_n, mac_mul(opa_i, opb_i));
        acc_n  = step_w.sum;
        prod_n = step_w.sum;
        if (step_w.wrap) carry_n = 1'b1;
      end
    end
    if (tick_i && !mode_n) begin
      prod_n = mac_mul(opa_i, opb_i);
      acc_n  = '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      carry_q <= 1'b0;
      prod_q  <= '0;
      acc_q   <= '0;
    end else begin
      mode_q  <= mode_n;
      carry_q <= carry_n;
      prod_q  <= prod_n;
      acc_q   <= acc_n;
    end
  end

  assign mode_o  = mode_q;
  assign carry_o = carry_q;
  assign prod_o  = prod_q;
  assign acc_o   = acc_q;
endmodule

// File: rtl/mac_side_unit.sv
module mac_side_unit
  import mac_side_pkg::*;
#(
  parameter int BASE_REG = 25,
  parameter int SEL_W    = 5,
  localparam int RB      = MAC_OP_W / 8,
  localparam int NREG    = 3,
  localparam int WIN_B   = NREG * RB,
  localparam int WIN_W   = 8 * WIN_B,
  localparam int LANE_W  = $clog2(RB),
  localparam int LEN_W   = $clog2(WIN_B + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [MAC_OP_W-1:0] opa_i,
  input  logic [MAC_OP_W-1:0] opb_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [LANE_W-1:0] wr_lane_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  input  logic [WIN_W-1:0]  wr_data_i,
  output logic              wr_err_o,
  input  logic              rd_en_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  input  logic [LANE_W-1:0] rd_lane_i,
  input  logic [LEN_W-1:0]  rd_len_i,
  output logic [WIN_W-1:0]  rd_data_o,
  output logic              rd_err_o,
  output logic              carry_o
);
  logic             wr_ok_w, rd_ok_w, touch_w, mode_w, carry_w;
  logic [7:0]       wr_start_w, rd_start_w;
  logic [WIN_B-1:0] wr_mask_w, rd_mask_w;
  logic [WIN_W-1:0] wr_win_w, state_win_w, rd_shift_w;
  mac_acc_t         prod_w, acc_w;
  logic             unused_rd_mask;

  mac_xfer_dec #(.BASE_REG(BASE_REG), .NREG(NREG), .RB(RB), .SEL_W(SEL_W),
                 .LANE_W(LANE_W), .LEN_W(LEN_W)) u_wr_dec (
    .en_i(wr_en_i), .sel_i(wr_sel_i), .lane_i(wr_lane_i), .len_i(wr_len_i),
    .ok_o(wr_ok_w), .err_o(wr_err_o), .start_o(wr_start_w), .mask_o(wr_mask_w));

  mac_xfer_dec #(.BASE_REG(BASE_REG), .NREG(NREG), .RB(RB), .SEL_W(SEL_W),
                 .LANE_W(LANE_W), .LEN_W(LEN_W)) u_rd_dec (
    .en_i(rd_en_i), .sel_i(rd_sel_i), .lane_i(rd_lane_i), .len_i(rd_len_i),
    .ok_o(rd_ok_w), .err_o(rd_err_o), .start_o(rd_start_w), .mask_o(rd_mask_w));

  assign unused_rd_mask = ^rd_mask_w;
  assign touch_w  = wr_ok_w && (wr_sel_i == SEL_W'(BASE_REG));
  assign wr_win_w = wr_data_i << {wr_start_w, 3'b000};

  mac_core #(.RB(RB)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .opa_i(opa_i), .opb_i(opb_i),
    .wr_ok_i(wr_ok_w), .touch_i(touch_w), .wr_mask_i(wr_mask_w), .wr_win_i(wr_win_w),
    .mode_o(mode_w), .carry_o(carry_w), .prod_o(prod_w), .acc_o(acc_w));

  assign state_win_w = {prod_w, {(8*RB-2){1'b0}}, carry_w, mode_w};
  assign rd_shift_w  = state_win_w >> {rd_start_w, 3'b000};

  for (genvar k = 0; k < WIN_B; k++) begin : g_rd
    assign rd_data_o[8*k +: 8] = (rd_ok_w && (8'(k) < 8'(rd_len_i))) ? rd_shift_w[8*k +: 8] : 8'h00;
  end

  assign carry_o = carry_w;
endmodule

// File: rtl/mac_side_unit_chk.sv
module mac_side_unit_chk #(
  parameter int OPW   = 32,
  parameter int WIN_B = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic             wr_err_o,
  input logic [OPW-1:0]   opa_i,
  input logic [OPW-1:0]   opb_i,
  input logic             touch_w,
  input logic [WIN_B-1:0] wr_mask_w,
  input logic [8*WIN_B-1:0] wr_win_w,
  input logic             mode_w,
  input logic             carry_w,
  input logic [2*OPW-1:0] prod_w,
  input logic [2*OPW-1:0] acc_w
);
  AST_ERR_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_err_o && !tick_i) |=> ($stable(prod_w) && $stable(acc_w) && $stable(mode_w) && $stable(carry_w))); // R3

  AST_MULONLY_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_w && tick_i && !wr_en_i) |=>
      (acc_w == '0 && prod_w == ((2*OPW)'($past(opa_i)) * (2*OPW)'($past(opb_i))))); // R4

  AST_ACC_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w && !wr_en_i) |=> ($stable(prod_w) && $stable(acc_w))); // R6

  AST_CARRY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_w && !touch_w) |=> carry_w); // R8

  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (touch_w && wr_mask_w[0] && wr_win_w[1] && !wr_win_w[0]) |=> (acc_w == '0 && !carry_w)); // R9
endmodule

bind mac_side_unit mac_side_unit_chk #(.OPW(32), .WIN_B(12)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i), .wr_err_o(wr_err_o),
  .opa_i(opa_i), .opb_i(opb_i), .touch_w(touch_w), .wr_mask_w(wr_mask_w), .wr_win_w(wr_win_w),
  .mode_w(mode_w), .carry_w(carry_w), .prod_w(prod_w), .acc_w(acc_w));

// File: tb/mac_side_unit_bench.sv
`timescale 1ns/1ps
module mac_side_unit_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [4:0]  wr_sel_i = '0, rd_sel_i = '0;
  logic [1:0]  wr_lane_i = '0, rd_lane_i = '0;
  logic [3:0]  wr_len_i = '0, rd_len_i = '0;
  logic [95:0] wr_data_i = '0;
  logic [95:0] rd_data_o;
  logic        wr_err_o, rd_err_o, carry_o;

  int n_chk = 0, n_bad = 0;
  logic        m_mode = 0, m_carry = 0;
  logic [63:0] m_prod = '0, m_acc = '0;

  always #2 clk_i = ~clk_i;

  mac_side_unit u_mac_side_unit (.*);

  task automatic chk(input string tag, input logic [95:0] got, input logic [95:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic bit bad_xfer(input logic [4:0] r, input logic [1:0] b, input logic [3:0] l);
    int s;
    s = (int'(r) - 25) * 4 + int'(b);
    return (r < 25) || (r > 27) || (l == 0) || (s + int'(l) > 12);
  endfunction

  function automatic logic [95:0] exp_read(input logic [4:0] r, input logic [1:0] b, input logic [3:0] l);
    logic [95:0] win, out;
    int s;
    out = '0;
    if (bad_xfer(r, b, l)) return out;
    win = {m_prod, 30'd0, m_carry, m_mode};
    s = (int'(r) - 25) * 4 + int'(b);
    for (int k = 0; k < int'(l); k++) out[8*k +: 8] = win[8*(s+k) +: 8];
    return out;
  endfunction

  task automatic model_apply(input bit tk, input bit we, input logic [4:0] r, input logic [1:0] b,
                             input logic [3:0] l, input logic [95:0] d, input logic [31:0] a, input logic [31:0] c);
    logic [64:0] t;
    int s, idx;
    if (we && !bad_xfer(r, b, l)) begin
      s = (int'(r) - 25) * 4 + int'(b);
      for (int k = 0; k < int'(l); k++) begin
        idx = s + k;
        if (idx == 0) begin
          m_mode = d[8*k];
          if (d[8*k+1]) begin m_carry = 0; m_acc = '0; end
        end else if (idx >= 4) m_prod[8*(idx-4) +: 8] = d[8*k +: 8];
      end
      if (r == 25 && m_mode) begin
        t = {1'b0, m_acc} + 65'(64'(a) * 64'(c));
        if (t[64]) m_carry = 1;
        m_acc = t[63:0];
        m_prod = t[63:0];
      end
    end
    if (tk && !m_mode) begin
      m_prod = 64'(a) * 64'(c);
      m_acc = '0;
    end
  endtask

  // Starts and ends at a falling edge.
  task automatic step(input string tag, input bit tk, input bit we, input logic [4:0] r, input logic [1:0] b,
                      input logic [3:0] l, input logic [95:0] d, input logic [31:0] a, input logic [31:0] c);
    tick_i = tk; wr_en_i = we; wr_sel_i = r; wr_lane_i = b; wr_len_i = l; wr_data_i = d;
    opa_i = a; opb_i = c;
    #1;
    if (we) chk({tag, " R3 wr_err"}, 96'(wr_err_o), 96'(bad_xfer(r, b, l)));
    @(posedge clk_i);
    model_apply(tk, we, r, b, l, d, a, c);
    @(negedge clk_i);
    tick_i = 0; wr_en_i = 0;
  endtask

  task automatic rd(input string tag, input logic [4:0] r, input logic [1:0] b, input logic [3:0] l);
    rd_en_i = 1; rd_sel_i = r; rd_lane_i = b; rd_len_i = l;
    #1;
    chk(tag, rd_data_o, exp_read(r, b, l));
    chk({tag, " R3 rd_err"}, 96'(rd_err_o), 96'(bad_xfer(r, b, l)));
    chk({tag, " R8 carry_o"}, 96'(carry_o), 96'(m_carry));
    @(negedge clk_i);
    rd_en_i = 0;
  endtask

  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    rd("R1 reset window", 25, 0, 12);
    step("R4", 1, 0, 0, 0, 0, '0, ONES, ONES);
    rd("R4 max product", 25, 0, 12);
    step("R5", 0, 0, 0, 0, 0, '0, 32'h1234, 32'h5678);
    rd("R5 no tick hold", 25, 0, 12);
    step("R7", 0, 1, 25, 0, 1, 96'h01, ONES, ONES);
    rd("R7 first accumulate", 25, 0, 12);
    step("R6", 1, 0, 0, 0, 0, '0, 32'h7, 32'h9);
    rd("R6 tick ignored", 25, 0, 12);
    step("R8", 0, 1, 25, 0, 1, 96'h01, ONES, ONES);
    rd("R8 wrap sets carry", 25, 0, 12);
    step("R9 keep", 0, 1, 25, 2, 1, 96'h00, 32'h3, 32'h5);
    rd("R9 write0 keeps carry, R7 lane2 accumulates", 25, 0, 12);
    step("R9 clr", 0, 1, 25, 0, 1, 96'h03, 32'h10, 32'h20);
    rd("R9 clear then accumulate", 25, 0, 12);
    step("R10", 0, 1, 26, 2, 3, 96'hA5B6C7, 32'h1, 32'h1);
    rd("R10 product bytes across boundary", 26, 0, 8);
    rd("R2 partial read reg26 lane3", 26, 3, 5);
    step("R3 lo", 0, 1, 24, 0, 4, '1, 32'h1, 32'h1);
    step("R3 hi", 0, 1, 28, 0, 1, '1, 32'h1, 32'h1);
    step("R3 len0", 0, 1, 25, 0, 0, '1, 32'h1, 32'h1);
    step("R3 overrun", 0, 1, 27, 1, 4, '1, 32'h1, 32'h1);
    rd("R3 state after rejects", 25, 0, 12);
    rd("R3 bad read", 27, 2, 3);
    step("R9 to mul", 0, 1, 25, 0, 1, 96'h02, 32'h1, 32'h1);
    step("R11", 1, 1, 26, 0, 8, '1, 32'hBEEF, 32'hCAFE);
    rd("R11 tick wins over product write", 25, 0, 12);
    for (int i = 0; i < 600; i++) begin
      int kind;
      logic [31:0] a, c;
      kind = int'($urandom % 5);
      a = ($urandom % 4 == 0) ? ONES : $urandom;
      c = ($urandom % 4 == 0) ? ONES : $urandom;
      case (kind)
        0: step("R4 rnd", 1, 0, 0, 0, 0, '0, a, c);
        1: step("R7 rnd", $urandom % 2, 1, 25, 0, 1, 96'($urandom % 4), a, c);
        2: step("R2 rnd", $urandom % 2, 1, 5'(23 + $urandom % 7), 2'($urandom), 4'($urandom), {$urandom, $urandom, $urandom}, a, c);
        3: step("R11 rnd", 1, 1, 5'(25 + $urandom % 3), 2'($urandom), 4'(1 + $urandom % 4), {$urandom, $urandom, $urandom}, a, c);
        default: step("R5 rnd", 0, 0, 0, 0, 0, '0, a, c);
      endcase
      if (i % 7 == 0) rd("R2 rnd read", 5'(24 + $urandom % 5), 2'($urandom), 4'($urandom));
      else rd("R4 R7 rnd window", 25, 0, 12);
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule